// File: doc/BRIEF.md
# Timer-Overflow Bit-Rate Tick Generator

This block derives the 16x oversampling ticks that a serial transmitter and receiver use as their bit-rate reference. It holds an 8-bit up-counter that reloads itself from a programmable value whenever it rolls over from all ones. The counter advances on a timer clock taken from one of three places: every system clock cycle, one system clock cycle in twelve, or each rising edge of an external input. Whether an overflow becomes a tick then depends on a speed-doubling control. With doubling off, only every second overflow becomes a tick. With doubling on, every overflow becomes a tick.

A second tick source is an overflow strobe from a 16-bit timer that lives outside this block. That strobe is passed on directly as a tick, with no halving. The transmit path and the receive path each have their own source select, so the two can run at different rates. Every tick is a single system-clock pulse. The serial logic counts sixteen of them per bit, which gives a bit rate of overflow rate / 32 (8-bit timer, doubling off), overflow rate / 16 (8-bit timer, doubling on) or 16-bit overflow rate / 16.

The speed-doubling control is owned by the register that drives `double_en`, which clears to 0 on reset, so the slower rate applies by default. All the control pins are plain levels sampled on the system clock. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `tx_tick` and `rx_tick` are 0 and the 8-bit counter is 0.
- R2: When the counter holds 0xFF and receives a timer clock, it loads `reload` and raises one overflow; otherwise it counts up by one. In steady state there are (256 - `reload`) timer clocks per overflow.
- R3: `clk_sel` encodes the timer clock: 0 = every system clock, 1 = every 12th system clock, 2 = external rising edges, 3 = no clock (the counter holds).
- R4: With `double_en` = 0, an 8-bit-sourced tick occurs on every second overflow. With `double_en` = 1, it occurs on every overflow.
- R5: With `tx_src_sel` = 1, each one-cycle pulse on `t16_ovf` produces a one-cycle `tx_tick` on the next cycle, and 8-bit overflows do not reach `tx_tick`.
- R6: `rx_src_sel` selects the receive tick source with the same encoding (0 = 8-bit timer, 1 = 16-bit strobe), independently of `tx_src_sel`.
- R7: While `run_en` is 0, the counter holds its value and raises no overflow, so no 8-bit-sourced ticks occur.
- R8: An isolated source event produces a tick exactly one system clock cycle long.
- R9: `ext_clk_in` passes through a two-flop synchronizer. Each rising edge gives exactly one timer clock, provided the input holds each level for at least two system clocks. A constant level gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | 8-bit timer run enable |
| clk_sel | input | 2 | Timer clock select (0 sys, 1 sys/12, 2 external, 3 off) |
| reload | input | 8 | Reload value for the 8-bit timer |
| double_en | input | 1 | 1 = tick on every 8-bit overflow, 0 = every second |
| ext_clk_in | input | 1 | Asynchronous external timer clock |
| t16_ovf | input | 1 | One-cycle overflow strobe from the 16-bit timer |
| tx_src_sel | input | 1 | Transmit tick source: 0 = 8-bit, 1 = 16-bit |
| rx_src_sel | input | 1 | Receive tick source: 0 = 8-bit, 1 = 16-bit |
| tx_tick | output | 1 | 16x tick to the transmitter |
| rx_tick | output | 1 | 16x tick to the receiver |

## Verification
A wrong counter value or a reload that is not applied shows up as a wrong spacing between consecutive ticks. This is visible within one overflow period: 256 - `reload` timer clocks, doubled when halving is active. A halving phase flop stuck in either state makes the tick spacing either equal to the overflow period or missing altogether. Both cases are caught on the second tick after a configuration change. A wrong source select or a leaking enable appears within a few cycles as ticks on a path that should be silent, or as a missing tick one cycle after a 16-bit strobe.

// File: rtl/baud_tick_pkg.sv
`timescale 1ns/1ps
package baud_tick_pkg;
  typedef enum logic [1:0] {
    TCLK_SYS  = 2'd0,
    TCLK_DIV  = 2'd1,
    TCLK_EXT  = 2'd2,
    TCLK_OFF  = 2'd3
  } tclk_sel_e;

  localparam int unsigned PRESCALE_DIV   = 12;
  localparam int unsigned SYNC_STAGES    = 2;
  localparam int unsigned TIMER8_W       = 8;
  localparam int unsigned NUM_PATHS      = 2;
  localparam int unsigned PATH_TX        = 0;
  localparam int unsigned PATH_RX        = 1;
endpackage

// File: rtl/timer_clk_enable.sv
`timescale 1ns/1ps
module timer_clk_enable
  import baud_tick_pkg::*;
#(
  parameter int unsigned DIV   = PRESCALE_DIV,
  parameter int unsigned SYNC  = SYNC_STAGES
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       ext_in,
  output logic       tick_en
);
  localparam int unsigned DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

  // free-running prescaler
  logic [DIV_W-1:0] div_cnt;
  logic             div_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
    end else if (div_hit) begin
      div_cnt <= '0;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  assign div_hit = (div_cnt == DIV_LAST);

  // synchronizer chain and edge detect for the external clock
  logic [SYNC-1:0] sync_q;
  logic            sync_prev;
  logic            ext_rise;

  generate
    if (SYNC == 1) begin : g_sync_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= ext_in;
      end
    end else begin : g_sync_many
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC-2:0], ext_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) sync_prev <= 1'b0;
    else        sync_prev <= sync_q[SYNC-1];
  end

  assign ext_rise = sync_q[SYNC-1] & ~sync_prev;

  // source mux
  tclk_sel_e sel_e;
  assign sel_e = tclk_sel_e'(sel);

  always_comb begin
    unique case (sel_e)
      TCLK_SYS: tick_en = 1'b1;
      TCLK_DIV: tick_en = div_hit;
      TCLK_EXT: tick_en = ext_rise;
      default:  tick_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/reload_timer.sv
`timescale 1ns/1ps
module reload_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  logic         tick_en,
  input  logic [W-1:0] reload,
  output logic [W-1:0] count,
  output logic         ovf
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic advance;
  assign advance = run_en & tick_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      ovf <= 1'b0;
      if (advance) begin
        if (count == TOP) begin
          count <= reload;
          ovf   <= 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ovf_halver.sv
`timescale 1ns/1ps
module ovf_halver (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic double_en,
  output logic tick
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      tick    <= 1'b0;
    end else begin
      tick <= ovf & (double_en | phase_q);
      if (ovf && !double_en) begin
        phase_q <= ~phase_q;
      end
    end
  end
endmodule

// File: rtl/baud_tick_gen.sv
`timescale 1ns/1ps
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int unsigned TW       = TIMER8_W,
  parameter int unsigned DIV      = PRESCALE_DIV,
  parameter int unsigned SYNC     = SYNC_STAGES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic [1:0]    clk_sel,
  input  logic [TW-1:0] reload,
  input  logic          double_en,
  input  logic          ext_clk_in,
  input  logic          t16_ovf,
  input  logic          tx_src_sel,
  input  logic          rx_src_sel,
  output logic          tx_tick,
  output logic          rx_tick
);
  logic          tmr_clk_en;
  logic [TW-1:0] t8_cnt;
  logic          t8_ovf;
  logic          t8_tick;

  timer_clk_enable #(.DIV(DIV), .SYNC(SYNC)) u_clk_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (clk_sel),
    .ext_in  (ext_clk_in),
    .tick_en (tmr_clk_en)
  );

  reload_timer #(.W(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .tick_en (tmr_clk_en),
    .reload  (reload),
    .count   (t8_cnt),
    .ovf     (t8_ovf)
  );

  ovf_halver u_half (
    .clk       (clk),
    .rst_n     (rst_n),
    .ovf       (t8_ovf),
    .double_en (double_en),
    .tick      (t8_tick)
  );

  // per-path source selection, registered
  logic [NUM_PATHS-1:0] path_sel;
  logic [NUM_PATHS-1:0] path_tick;

  assign path_sel[PATH_TX] = tx_src_sel;
  assign path_sel[PATH_RX] = rx_src_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      path_tick <= '0;
    end else begin
      for (int p = 0; p < NUM_PATHS; p++) begin
        path_tick[p] <= path_sel[p] ? t16_ovf : t8_tick;
      end
    end
  end

  assign tx_tick = path_tick[PATH_TX];
  assign rx_tick = path_tick[PATH_RX];
endmodule

// File: rtl/baud_tick_gen_chk.sv
`timescale 1ns/1ps
module baud_tick_gen_chk #(
  parameter int unsigned TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_en,
  input logic [1:0]    clk_sel,
  input logic [TW-1:0] reload,
  input logic          t16_ovf,
  input logic          tx_src_sel,
  input logic          rx_src_sel,
  input logic          tx_tick,
  input logic          rx_tick,
  input logic [TW-1:0] cnt,
  input logic          ovf
);
  localparam logic [TW-1:0] TOP = {TW{1'b1}};

  assert_ovf_from_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> ($past(cnt) == TOP));

  assert_reload_applied_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (cnt == $past(reload)));

  assert_no_clock_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'd3) |=> $stable(cnt));

  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> ($stable(cnt) && !ovf));

  assert_t16_to_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_src_sel && t16_ovf) |=> tx_tick);

  assert_t16_to_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_src_sel && t16_ovf) |=> rx_tick);
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.TW(TW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_en     (run_en),
  .clk_sel    (clk_sel),
  .reload     (reload),
  .t16_ovf    (t16_ovf),
  .tx_src_sel (tx_src_sel),
  .rx_src_sel (rx_src_sel),
  .tx_tick    (tx_tick),
  .rx_tick    (rx_tick),
  .cnt        (t8_cnt),
  .ovf        (t8_ovf)
);

// File: tb/baud_tick_gen_tb_top.sv
`timescale 1ns/1ps
module baud_tick_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0;
  logic [1:0] clk_sel = 2'd3;
  logic [7:0] reload = 8'h00;
  logic       double_en = 1'b0;
  logic       ext_clk_in = 1'b0;
  logic       t16_ovf = 1'b0;
  logic       tx_src_sel = 1'b0;
  logic       rx_src_sel = 1'b0;
  logic       tx_tick;
  logic       rx_tick;

  int n_run = 0;
  int n_fail = 0;
  bit ext_run = 1'b0;
  int ext_ph = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  baud_tick_gen dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .clk_sel    (clk_sel),
    .reload     (reload),
    .double_en  (double_en),
    .ext_clk_in (ext_clk_in),
    .t16_ovf    (t16_ovf),
    .tx_src_sel (tx_src_sel),
    .rx_src_sel (rx_src_sel),
    .tx_tick    (tx_tick),
    .rx_tick    (rx_tick)
  );

  // external clock: 4 cycles high, 4 low
  initial begin
    forever begin
      @(negedge clk);
      if (ext_run) begin
        ext_ph++;
        if (ext_ph == 4) begin
          ext_clk_in = ~ext_clk_in;
          ext_ph = 0;
        end
      end
    end
  end

  // {clk_sel, reload, double_en, expected cycles between ticks}
  localparam int NV = 7;
  localparam logic [26:0] VEC [0:NV-1] = '{
    {2'd0, 8'hF0, 1'b1, 16'd16},   // R2 R4 doubling on
    {2'd0, 8'hF0, 1'b0, 16'd32},   // R4 halving
    {2'd0, 8'hC8, 1'b1, 16'd56},   // R2 other reload
    {2'd1, 8'hF8, 1'b1, 16'd96},   // R3 div by 12
    {2'd1, 8'hFC, 1'b0, 16'd96},   // R3 R4
    {2'd0, 8'hFF, 1'b1, 16'd1},    // R2 reload all ones
    {2'd0, 8'hFE, 1'b0, 16'd4}     // R4 short
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // cycles until next tick on selected path (0 tx, 1 rx)
  task automatic next_tick(input bit on_rx, output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!(on_rx ? rx_tick : tx_tick) && cyc < 5000);
  endtask

  task automatic period(input bit on_rx, output int cyc);
    int skip;
    next_tick(on_rx, skip);
    next_tick(on_rx, skip);
    next_tick(on_rx, cyc);
  endtask

  task automatic count_ticks(input int n, output int tx_n, output int rx_n);
    tx_n = 0;
    rx_n = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_n += int'(tx_tick);
      rx_n += int'(rx_tick);
    end
  endtask

  initial begin
    int cyc;
    int txn;
    int rxn;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 tx_tick in reset", int'(tx_tick), 0);
    check("R1 rx_tick in reset", int'(rx_tick), 0);
    rst_n = 1'b1;
    run_en = 1'b1;
    @(negedge clk);
    check("R1 ticks after reset", int'(tx_tick | rx_tick), 0);

    // R3 no clock: silence
    count_ticks(300, txn, rxn);
    check("R3 clk_sel=3 tx ticks", txn, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      clk_sel   = VEC[v][26:25];
      reload    = VEC[v][24:17];
      double_en = VEC[v][16];
      period(1'b0, cyc);
      check($sformatf("R2/R3/R4 vector %0d tx period", v), cyc, int'(VEC[v][15:0]));
    end

    // R6 independent selection
    clk_sel = 2'd0; reload = 8'hF0; double_en = 1'b1;
    tx_src_sel = 1'b1; rx_src_sel = 1'b0;
    period(1'b1, cyc);
    check("R6 rx on 8-bit period", cyc, 16);
    count_ticks(100, txn, rxn);
    check("R6 tx on idle 16-bit source", txn, 0);
    tx_src_sel = 1'b0; rx_src_sel = 1'b1;
    period(1'b0, cyc);
    check("R6 tx on 8-bit period", cyc, 16);
    count_ticks(100, txn, rxn);
    check("R6 rx on idle 16-bit source", rxn, 0);

    // R5 / R8 16-bit strobe
    clk_sel = 2'd3; tx_src_sel = 1'b1; rx_src_sel = 1'b0;
    repeat (4) @(negedge clk);
    t16_ovf = 1'b1;
    @(negedge clk);
    t16_ovf = 1'b0;
    check("R5 tx_tick after strobe", int'(tx_tick), 1);
    check("R6 rx_tick not on strobe", int'(rx_tick), 0);
    @(negedge clk);
    check("R8 tx_tick one cycle", int'(tx_tick), 0);
    rx_src_sel = 1'b1;
    t16_ovf = 1'b1;
    @(negedge clk);
    t16_ovf = 1'b0;
    check("R6 rx_tick after strobe", int'(rx_tick), 1);
    @(negedge clk);
    check("R8 rx_tick one cycle", int'(rx_tick), 0);

    // R7 freeze
    tx_src_sel = 1'b0; rx_src_sel = 1'b0;
    clk_sel = 2'd0; reload = 8'hF0; double_en = 1'b1;
    period(1'b0, cyc);
    run_en = 1'b0;
    repeat (3) @(negedge clk);
    count_ticks(300, txn, rxn);
    check("R7 no ticks while stopped", txn + rxn, 0);
    run_en = 1'b1;
    next_tick(1'b0, cyc);
    check("R7 resumes within one period", int'(cyc <= 16), 1);

    // R9 external clock
    reload = 8'hFE; clk_sel = 2'd2; ext_run = 1'b1;
    period(1'b0, cyc);
    check("R9 external edges period", cyc, 16);
    ext_run = 1'b0;
    repeat (6) @(negedge clk);
    count_ticks(200, txn, rxn);
    check("R9 constant level no ticks", txn, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule